// File: doc/BRIEF.md
# Floppy Controller Bus Glue

This block sits between an 8-bit CPU bus and an external floppy disk controller mapped into I/O page 3. Each cycle it looks at the address the CPU presents and works out whether the access targets one of the controller's four internal registers, the glue's own control latch, or the glue's data-request status location. For a controller access it asserts an active-low chip select and passes the two low address bits through as the register index. Any access to the controller window or to a glue location also raises an override output. That output tells the board to keep its own on-board I/O device off the bus.

The control latch can only be written. Its fields drive four one-hot drive enables, the side select, the density and separator-divisor controls, the internal-ROM disable and the expansion-EPROM select. It also holds the interrupt enable, which gates the controller's interrupt through a NAND. The NAND output is the active-low CPU interrupt, and the same value can be read back at the control address. Software can therefore poll for command completion without reading the controller's status register, which would clear the interrupt. A second location reads back the controller's data request in active-low form.

Top module: `fdc_glue`

## Requirements
- R1: An access (bus_en high) to 0x0310..0x0313 drives fdc_cs_n low and fdc_reg to addr[1:0]. fdc_cs_n is high for every other address and whenever bus_en is low.
- R2: A write to 0x0314 is captured at the clock edge. Bit 7 drives eprom_sel_n, bits 6:5 the drive number, bit 4 side, bit 3 single_den (0 = double density), bit 2 sep_div, bit 1 rom_dis_n and bit 0 irq_en.
- R3: Reset loads the control byte 0x86: eprom_sel_n=1, drive 0, side=0, single_den=0, sep_div=1, rom_dis_n=1, irq_en=0.
- R4: cpu_irq_n equals NOT(fdc_intrq AND irq_en) at all times.
- R5: A read of 0x0314 returns {NOT(fdc_intrq AND irq_en), 7'b0} on rdata.
- R6: A read of 0x0318 returns {NOT fdc_drq, 7'b0}. Bit 7 is 0 when a byte is ready.
- R7: A read of 0x0314 leaves fdc_cs_n high and does not change cpu_irq_n, so the controller's interrupt condition is untouched.
- R8: io_ovr is high during any access to 0x0310..0x0314 or 0x0318, and low otherwise.
- R9: drive_en is one-hot, with bit n set when the latched drive number is n.
- R10: Writes to addresses other than 0x0314, and reads of 0x0314, leave the control latch unchanged.
- R11: rdata is 0 when the access is not a read of 0x0314 or 0x0318.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | CPU access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Glue read-back data |
| fdc_intrq | input | 1 | Controller interrupt request, active high |
| fdc_drq | input | 1 | Controller data request, active high |
| fdc_cs_n | output | 1 | Controller chip select, active low |
| fdc_reg | output | 2 | Controller register index |
| io_ovr | output | 1 | On-board I/O disable |
| cpu_irq_n | output | 1 | Gated CPU interrupt, active low |
| drive_en | output | 4 | One-hot drive enables |
| side | output | 1 | Side select |
| single_den | output | 1 | 1 = single density |
| sep_div | output | 1 | Separator clock divisor select |
| rom_dis_n | output | 1 | Internal ROM disable, active low |
| eprom_sel_n | output | 1 | Expansion EPROM select, active low |
| irq_en | output | 1 | Latched interrupt enable |

## Verification
The hardest case to reach is an interrupt that is pending while the enable is off and then becomes visible without a new controller edge. The bench holds fdc_intrq high and reads 0x0314 with the enable clear, expecting bit 7 to be 1. It then writes the enable, expects the IRQ and the read-back bit to fall together, and reads 0x0314 again to confirm that the read changes neither the chip select nor the IRQ. Near-miss addresses such as 0x0315, 0x0317 and 0x0410 confirm that the decode stays silent.

// File: rtl/fdcg_pkg.sv
package fdcg_pkg;
  typedef struct packed {
    logic       eprom_n;
    logic [1:0] drive;
    logic       side;
    logic       sden;
    logic       div;
    logic       romdis_n;
    logic       ien;
  } ctrl_t;

  localparam logic [3:0] CTRL_NIB = 4'h4;
  localparam logic [3:0] DRQ_NIB  = 4'h8;
endpackage

// File: rtl/fdcg_decode.sv
module fdcg_decode #(
  parameter int ADDR_W = 16,
  parameter logic [15:0] BASE = 16'h0310
) (
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_fdc,
  output logic              hit_ctrl,
  output logic              hit_drq,
  output logic [1:0]        reg_idx
);
  import fdcg_pkg::*;
  localparam logic [ADDR_W-5:0] PAGE = BASE[ADDR_W-1:4];

  logic       in_page;
  logic [3:0] nib;

  always_comb begin
    in_page  = bus_en && (addr[ADDR_W-1:4] == PAGE);
    nib      = addr[3:0];
    hit_fdc  = in_page && (nib[3:2] == 2'b00);
    hit_ctrl = in_page && (nib == CTRL_NIB);
    hit_drq  = in_page && (nib == DRQ_NIB);
    reg_idx  = addr[1:0];
  end
endmodule

// File: rtl/fdcg_ctrl.sv
module fdcg_ctrl #(
  parameter int NDRV = 4,
  parameter logic [7:0] RST_VAL = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output fdcg_pkg::ctrl_t   ctrl,
  output logic [NDRV-1:0]   drive_en
);
  import fdcg_pkg::*;
  ctrl_t q;

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= ctrl_t'(RST_VAL);
    else if (wr) q <= ctrl_t'(wdata);
  end

  assign ctrl = q;

  for (genvar i = 0; i < NDRV; i++) begin : g_drv
    assign drive_en[i] = (q.drive == i[1:0]);
  end
endmodule

// File: rtl/fdcg_status.sv
module fdcg_status (
  input  logic       rd_ctrl,
  input  logic       rd_drq,
  input  logic       intrq,
  input  logic       drq,
  input  logic       ien,
  output logic       irq_n,
  output logic [7:0] rdata
);
  logic gated_n;

  always_comb begin
    gated_n = ~(intrq & ien);
    irq_n   = gated_n;
    rdata   = 8'h00;
    if (rd_ctrl)     rdata[7] = gated_n;
    else if (rd_drq) rdata[7] = ~drq;
  end
endmodule

// File: rtl/fdc_glue.sv
module fdc_glue #(
  parameter int ADDR_W = 16,
  parameter logic [15:0] BASE = 16'h0310,
  parameter int NDRV = 4,
  parameter logic [7:0] RST_VAL = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              fdc_intrq,
  input  logic              fdc_drq,
  output logic              fdc_cs_n,
  output logic [1:0]        fdc_reg,
  output logic              io_ovr,
  output logic              cpu_irq_n,
  output logic [NDRV-1:0]   drive_en,
  output logic              side,
  output logic              single_den,
  output logic              sep_div,
  output logic              rom_dis_n,
  output logic              eprom_sel_n,
  output logic              irq_en
);
  import fdcg_pkg::*;

  logic  hit_fdc, hit_ctrl, hit_drq;
  logic  ctrl_wr;
  ctrl_t ctrl_q;

  fdcg_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .bus_en(bus_en), .addr(addr), .hit_fdc(hit_fdc),
    .hit_ctrl(hit_ctrl), .hit_drq(hit_drq), .reg_idx(fdc_reg)
  );

  assign ctrl_wr = hit_ctrl && bus_we;

  fdcg_ctrl #(.NDRV(NDRV), .RST_VAL(RST_VAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(wdata),
    .ctrl(ctrl_q), .drive_en(drive_en)
  );

  fdcg_status u_stat (
    .rd_ctrl(hit_ctrl && !bus_we), .rd_drq(hit_drq && !bus_we),
    .intrq(fdc_intrq), .drq(fdc_drq), .ien(ctrl_q.ien),
    .irq_n(cpu_irq_n), .rdata(rdata)
  );

  assign fdc_cs_n    = ~hit_fdc;
  assign io_ovr      = hit_fdc | hit_ctrl | hit_drq;
  assign side        = ctrl_q.side;
  assign single_den  = ctrl_q.sden;
  assign sep_div     = ctrl_q.div;
  assign rom_dis_n   = ctrl_q.romdis_n;
  assign eprom_sel_n = ctrl_q.eprom_n;
  assign irq_en      = ctrl_q.ien;
endmodule

// File: rtl/fdc_glue_chk.sv
module fdc_glue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        fdc_intrq,
  input logic        fdc_cs_n,
  input logic        io_ovr,
  input logic        cpu_irq_n,
  input logic [3:0]  drive_en,
  input logic        irq_en,
  input logic [7:0]  ctrl_q
);
  logic past_ok;
  logic wr_ctrl;
  always_ff @(posedge clk) past_ok <= rst_n;
  assign wr_ctrl = bus_en && bus_we && (addr == 16'h0314);

  // R1
  cs_implies_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_cs_n |-> io_ovr);
  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_ctrl) |=> (ctrl_q == $past(wdata)));
  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_n == !(fdc_intrq && irq_en));
  // R7
  status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && addr == 16'h0314) |-> fdc_cs_n);
  // R9
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drive_en) == 1);
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !wr_ctrl) |=> $stable(ctrl_q));
endmodule

bind fdc_glue fdc_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .addr(addr),
  .wdata(wdata), .fdc_intrq(fdc_intrq), .fdc_cs_n(fdc_cs_n), .io_ovr(io_ovr),
  .cpu_irq_n(cpu_irq_n), .drive_en(drive_en), .irq_en(irq_en),
  .ctrl_q(ctrl_q)
);

// File: tb/fdc_glue_tb.sv
module fdc_glue_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wdata = 8'h00;
  logic fdc_intrq = 1'b0, fdc_drq = 1'b0;
  logic [7:0] rdata;
  logic fdc_cs_n, io_ovr, cpu_irq_n, side, single_den, sep_div;
  logic rom_dis_n, eprom_sel_n, irq_en;
  logic [1:0] fdc_reg;
  logic [3:0] drive_en;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  fdc_glue u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fdc_intrq(fdc_intrq), .fdc_drq(fdc_drq),
    .fdc_cs_n(fdc_cs_n), .fdc_reg(fdc_reg), .io_ovr(io_ovr),
    .cpu_irq_n(cpu_irq_n), .drive_en(drive_en), .side(side),
    .single_den(single_den), .sep_div(sep_div), .rom_dis_n(rom_dis_n),
    .eprom_sel_n(eprom_sel_n), .irq_en(irq_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs_byte();
    logic [1:0] d;
    d = drive_en[3] ? 2'd3 : drive_en[2] ? 2'd2 : drive_en[1] ? 2'd1 : 2'd0;
    return {eprom_sel_n, d, side, single_den, sep_div, rom_dis_n, irq_en};
  endfunction

  task automatic idle();
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; addr = 16'h0000;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_setup(input logic [15:0] a);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; addr = a;
    #1;
  endtask

  task automatic t_reset();
    check("R3 reset byte", outs_byte(), 8'h86);
    check("R9 reset drive", drive_en, 4'b0001);
    check("R1 idle cs", fdc_cs_n, 1);
    check("R8 idle ovr", io_ovr, 0);
  endtask

  task automatic t_decode();
    for (int i = 0; i < 4; i++) begin
      rd_setup(16'h0310 + 16'(i));
      check("R1 cs", fdc_cs_n, 0);
      check("R1 idx", fdc_reg, i);
      check("R8 ovr fdc", io_ovr, 1);
      check("R11 rdata fdc", rdata, 0);
    end
    rd_setup(16'h0315); check("R1 cs 315", fdc_cs_n, 1); check("R8 ovr 315", io_ovr, 0);
    rd_setup(16'h0317); check("R8 ovr 317", io_ovr, 0);
    rd_setup(16'h0410); check("R1 cs 410", fdc_cs_n, 1); check("R8 ovr 410", io_ovr, 0);
    check("R11 rdata other", rdata, 0);
    rd_setup(16'h0318); check("R8 ovr 318", io_ovr, 1); check("R1 cs 318", fdc_cs_n, 1);
    @(negedge clk); bus_en = 1'b0; addr = 16'h0312; #1;
    check("R1 cs no strobe", fdc_cs_n, 1);
    idle();
  endtask

  task automatic t_latch();
    wr(16'h0314, 8'h5A);
    check("R2 latch 5A", outs_byte(), 8'h5A);
    check("R9 drive 2", drive_en, 4'b0100);
    wr(16'h0314, 8'hA5);
    check("R2 latch A5", outs_byte(), 8'hA5);
    check("R9 drive 1", drive_en, 4'b0010);
    wr(16'h0314, 8'h60);
    check("R9 drive 3", drive_en, 4'b1000);
    wr(16'h0315, 8'hFF);
    check("R10 other write", outs_byte(), 8'h60);
    wr(16'h0318, 8'h01);
    check("R10 drq write", outs_byte(), 8'h60);
    rd_setup(16'h0314); idle();
    check("R10 read", outs_byte(), 8'h60);
  endtask

  task automatic t_irq();
    wr(16'h0314, 8'h86);
    fdc_intrq = 1'b1;
    rd_setup(16'h0314);
    check("R5 disabled pending", rdata, 8'h80);
    check("R4 disabled", cpu_irq_n, 1);
    idle();
    wr(16'h0314, 8'h87);
    check("R4 enabled pending", cpu_irq_n, 0);
    rd_setup(16'h0314);
    check("R5 enabled pending", rdata, 8'h00);
    check("R7 cs", fdc_cs_n, 1);
    @(negedge clk); #1;
    check("R7 irq held", cpu_irq_n, 0);
    idle();
    fdc_intrq = 1'b0; #1;
    check("R4 cleared", cpu_irq_n, 1);
    rd_setup(16'h0314);
    check("R5 no pending", rdata, 8'h80);
    idle();
  endtask

  task automatic t_drq();
    fdc_drq = 1'b1;
    rd_setup(16'h0318);
    check("R6 drq set", rdata, 8'h00);
    fdc_drq = 1'b0; #1;
    check("R6 drq clear", rdata, 8'h80);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_decode();
        t_latch();
        t_irq();
        t_drq();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule